// File: doc/BRIEF.md
# Four-Queue Steering Unit

This unit sits in front of and behind four equal queues and decides which queue takes each incoming word and which queue drives each part of a 40-bit output bus. The operating mode is captured while reset is held and stays fixed until the next reset. Three modes exist. In the single-port mode, one 10-bit stream is steered into a chosen queue, and a 2-bit select picks which queue is read. In the split mode, each queue owns a 10-bit lane of the input and output buses. In the copy mode, one 10-bit word is written to all four queues at once.

A second bit captured at reset picks between two read timings for the single-port mode. In the plain timing, a read is requested explicitly and the word appears after one edge. In the look-ahead timing, the head of the selected queue is presented on the bus without any read request, after a short select pipeline. A summary flag reports whether the selected queue holds data. Per-queue "has data" and "full" flags are always visible. Writes are gated by the full flags. In copy mode, one full queue blocks the write to every queue, so that the four copies stay aligned.

Top module: `quad_steer`

## Requirements
- R1: `mode_i` and `fwft_i` are captured only while `rst_n` is low. Code 0 selects single-port mode, code 2 selects copy mode, and any other code selects split mode. Later changes to these inputs have no effect until the next reset.
- R2: During and straight after reset, `dout_o` is all zeros, `nempty_o`, `full_o` and `comp_o` are zero, and every queue is empty.
- R3: In single-port mode, `wen_i[0]` writes `din_i[9:0]` into the queue numbered by `wsel_i` only. `wen_i[3:1]` and `din_i[39:10]` are ignored.
- R4: In single-port mode with plain timing, `ren_i[0]` high with `rcs_n_i` low pops the queue named by `osel_i`. At the next edge its head appears on `dout_o[9:0]`, with `dout_o[39:10]` at zero. If that queue is empty, `dout_o` holds its value.
- R5: While `rcs_n_i` is high, `dout_o` holds its value and no queue is popped.
- R6: In single-port mode with plain timing, `comp_o` shows whether the newly selected queue holds data from the second edge after `osel_i` changes onward.
- R7: In single-port mode with look-ahead timing, `comp_o` follows the new selection from the third edge after `osel_i` changes onward. In the other modes, `comp_o` stays 0.
- R8: In look-ahead timing, while `rcs_n_i` is low, the head of the selected queue reaches `dout_o[9:0]` at the third edge after `osel_i` changes, with no read request. A read request pops that queue, and the following word is shown one edge after the pop.
- R9: In split mode, `wen_i[k]` writes lane k of `din_i` (bits 10k+9 down to 10k) into queue k. `ren_i[k]` pops queue k into the same lane of `dout_o`. Lanes that are not read, or whose queue is empty, hold their value.
- R10: In copy mode, `wen_i[0]` writes `din_i[9:0]` into all four queues. Reads work per lane as in split mode.
- R11: In copy mode, if any `full_o` bit is high, no queue accepts the write.
- R12: In the other modes, a full queue rejects only its own write. Fullness is judged on the state before the edge, so a write and a pop hitting a full queue on the same edge lose the write.
- R13: `nempty_o[k]` and `full_o[k]` report queue k after each edge, whatever the selection and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_i | input | 2 | Mode code, captured during reset |
| fwft_i | input | 1 | Look-ahead read timing when 1, captured during reset |
| wen_i | input | 4 | Write enables (bit 0 only in single-port and copy modes) |
| wsel_i | input | 2 | Destination queue in single-port mode |
| din_i | input | 40 | Write data, four 10-bit lanes |
| ren_i | input | 4 | Read requests (bit 0 only in single-port mode) |
| rcs_n_i | input | 1 | Active-low read select; high freezes the read side |
| osel_i | input | 2 | Queue read in single-port mode |
| dout_o | output | 40 | Read data, four 10-bit lanes |
| nempty_o | output | 4 | Per-queue holds-data flags |
| full_o | output | 4 | Per-queue full flags |
| comp_o | output | 1 | Holds-data flag of the selected queue (single-port mode) |

## Verification
The case of interest is a write and a pop that reach the same full queue on one edge. The bench provokes it in single-port mode, by reading a full queue while writing to it. It also provokes it in copy mode, by popping the one full queue while a copy write is offered. In both cases the bench judges that the write was lost, by draining the queues and confirming that the offered word never appears and that the has-data flags match. The scoreboard pairs each read with the word the requirements predict, due on the exact edge given by the mode's latency.

// File: rtl/qs_pkg.sv
package qs_pkg;
    localparam int QN    = 4;
    localparam int SEL_W = $clog2(QN);

    typedef enum logic [1:0] {
        MD_MUX   = 2'd0,
        MD_DEMUX = 2'd1,
        MD_BCAST = 2'd2
    } qs_mode_e;

    function automatic qs_mode_e decode_mode(input logic [1:0] code,
                                             input logic [1:0] mux_code,
                                             input logic [1:0] bc_code);
        if (code == mux_code) return MD_MUX;
        else if (code == bc_code) return MD_BCAST;
        else return MD_DEMUX;
    endfunction
endpackage

// File: rtl/qs_fifo.sv
module qs_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         nempty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        if (pop_i)  st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        if (push_i && !pop_i)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_i && !push_i) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[st_q.wp] <= wdata_i;
    end

    assign head_o   = mem[st_q.rp];
    assign full_o   = (st_q.cnt == CW'(DEPTH));
    assign nempty_o = (st_q.cnt != '0);
endmodule

// File: rtl/qs_wr_gate.sv
module qs_wr_gate
    import qs_pkg::*;
#(
    parameter int W = 10
) (
    input  qs_mode_e                mode_i,
    input  logic [QN-1:0]           wen_i,
    input  logic [SEL_W-1:0]        wsel_i,
    input  logic [QN*W-1:0]         din_i,
    input  logic [QN-1:0]           full_i,
    output logic [QN-1:0]           we_o,
    output logic [QN-1:0][W-1:0]    wdata_o
);
    logic any_full;
    assign any_full = |full_i;

    for (genvar g = 0; g < QN; g++) begin : g_lane
        always_comb begin
            unique case (mode_i)
                MD_MUX: begin
                    we_o[g]    = wen_i[0] && (wsel_i == SEL_W'(g)) && !full_i[g];
                    wdata_o[g] = din_i[W-1:0];
                end
                MD_BCAST: begin
                    we_o[g]    = wen_i[0] && !any_full;
                    wdata_o[g] = din_i[W-1:0];
                end
                default: begin
                    we_o[g]    = wen_i[g] && !full_i[g];
                    wdata_o[g] = din_i[g*W +: W];
                end
            endcase
        end
    end
endmodule

// File: rtl/qs_rd_path.sv
module qs_rd_path
    import qs_pkg::*;
#(
    parameter int W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  qs_mode_e                mode_i,
    input  logic                    fwft_i,
    input  logic [QN-1:0]           ren_i,
    input  logic                    rcs_n_i,
    input  logic [SEL_W-1:0]        osel_i,
    input  logic [QN-1:0][W-1:0]    head_i,
    input  logic [QN-1:0]           nempty_i,
    output logic [QN-1:0]           pop_o,
    output logic [QN*W-1:0]         dout_o,
    output logic                    comp_o
);
    localparam int BUS_W = QN * W;

    typedef struct packed {
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel2;
        logic [BUS_W-1:0] dout;
        logic             comp;
    } rd_st_t;

    rd_st_t st_d, st_q;
    logic   cs;
    logic [SEL_W-1:0] flag_sel;

    assign cs       = !rcs_n_i;
    assign flag_sel = fwft_i ? st_q.sel2 : st_q.sel1;

    always_comb begin
        st_d      = st_q;
        pop_o     = '0;
        st_d.sel1 = osel_i;
        st_d.sel2 = st_q.sel1;
        if (mode_i == MD_MUX) begin
            st_d.comp = nempty_i[flag_sel];
            if (!fwft_i) begin
                if (cs && ren_i[0] && nempty_i[osel_i]) begin
                    pop_o[osel_i] = 1'b1;
                    st_d.dout     = BUS_W'(head_i[osel_i]);
                end
            end else begin
                if (cs && nempty_i[st_q.sel2]) begin
                    st_d.dout = BUS_W'(head_i[st_q.sel2]);
                    if (ren_i[0]) pop_o[st_q.sel2] = 1'b1;
                end
            end
        end else begin
            st_d.comp = 1'b0;
            for (int l = 0; l < QN; l++) begin
                if (cs && ren_i[l] && nempty_i[l]) begin
                    pop_o[l]             = 1'b1;
                    st_d.dout[l*W +: W]  = head_i[l];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout_o = st_q.dout;
    assign comp_o = st_q.comp;
endmodule

// File: rtl/quad_steer.sv
module quad_steer
    import qs_pkg::*;
#(
    parameter int         LANE_W     = 10,
    parameter int         DEPTH      = 8,
    parameter logic [1:0] MUX_CODE   = 2'd0,
    parameter logic [1:0] BCAST_CODE = 2'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic                 fwft_i,
    input  logic [3:0]           wen_i,
    input  logic [1:0]           wsel_i,
    input  logic [4*LANE_W-1:0]  din_i,
    input  logic [3:0]           ren_i,
    input  logic                 rcs_n_i,
    input  logic [1:0]           osel_i,
    output logic [4*LANE_W-1:0]  dout_o,
    output logic [3:0]           nempty_o,
    output logic [3:0]           full_o,
    output logic                 comp_o
);
    localparam int BUS_W = QN * LANE_W;

    typedef struct packed {
        qs_mode_e mode;
        logic     fwft;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.mode = decode_mode(mode_i, MUX_CODE, BCAST_CODE);
            cfg_d.fwft = fwft_i;
        end
    end

    always_ff @(posedge clk) cfg_q <= cfg_d;

    qs_mode_e                   mode_cur;
    logic [QN-1:0]              we_w;
    logic [QN-1:0]              pop_w;
    logic [QN-1:0]              full_w;
    logic [QN-1:0]              ne_w;
    logic [QN-1:0][LANE_W-1:0]  wdata_w;
    logic [QN-1:0][LANE_W-1:0]  head_w;

    assign mode_cur = cfg_q.mode;

    qs_wr_gate #(.W(LANE_W)) u_wr (
        .mode_i  (mode_cur),
        .wen_i   (wen_i),
        .wsel_i  (wsel_i),
        .din_i   (din_i),
        .full_i  (full_w),
        .we_o    (we_w),
        .wdata_o (wdata_w)
    );

    for (genvar g = 0; g < QN; g++) begin : g_q
        qs_fifo #(.W(LANE_W), .DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_i   (we_w[g]),
            .pop_i    (pop_w[g]),
            .wdata_i  (wdata_w[g]),
            .head_o   (head_w[g]),
            .full_o   (full_w[g]),
            .nempty_o (ne_w[g])
        );
    end

    qs_rd_path #(.W(LANE_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_cur),
        .fwft_i   (cfg_q.fwft),
        .ren_i    (ren_i),
        .rcs_n_i  (rcs_n_i),
        .osel_i   (osel_i),
        .head_i   (head_w),
        .nempty_i (ne_w),
        .pop_o    (pop_w),
        .dout_o   (dout_o),
        .comp_o   (comp_o)
    );

    assign nempty_o = ne_w;
    assign full_o   = full_w;
endmodule

// File: rtl/qs_chk.sv
module qs_chk
    import qs_pkg::*;
#(
    parameter int BUS_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input qs_mode_e         mode_cur,
    input logic [QN-1:0]    we_w,
    input logic [QN-1:0]    pop_w,
    input logic [QN-1:0]    full_o,
    input logic [QN-1:0]    nempty_o,
    input logic             rcs_n_i,
    input logic [BUS_W-1:0] dout_o,
    input logic             comp_o
);
    for (genvar g = 0; g < QN; g++) begin : g_q
        AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            we_w[g] |-> !full_o[g]);  // R12
        AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            pop_w[g] |-> nempty_o[g]);  // R13
        AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
            full_o[g] |-> nempty_o[g]);  // R13
    end

    AST_COPY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MD_BCAST && |full_o) |-> (we_w == '0));  // R11
    AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur == MD_MUX) |-> $onehot0(we_w));  // R3
    AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rcs_n_i |=> $stable(dout_o));  // R5
    AST_CS_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rcs_n_i |-> (pop_w == '0));  // R5
    AST_COMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cur != MD_MUX) |=> !comp_o);  // R7
endmodule

bind quad_steer qs_chk #(.BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_cur (mode_cur),
    .we_w     (we_w),
    .pop_w    (pop_w),
    .full_o   (full_o),
    .nempty_o (nempty_o),
    .rcs_n_i  (rcs_n_i),
    .dout_o   (dout_o),
    .comp_o   (comp_o)
);

// File: tb/quad_steer_tb.sv
module quad_steer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic        fwft_i = 1'b0;
    logic [3:0]  wen = '0;
    logic [1:0]  wsel = '0;
    logic [39:0] din = '0;
    logic [3:0]  ren = '0;
    logic        rcs_n = 1'b0;
    logic [1:0]  osel = '0;
    logic [39:0] dout;
    logic [3:0]  nempty;
    logic [3:0]  full;
    logic        comp;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [39:0] val;
        string       req;
    } exp_t;
    exp_t sbq[$];
    exp_t item;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_steer #(.LANE_W(10), .DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .fwft_i(fwft_i),
        .wen_i(wen), .wsel_i(wsel), .din_i(din), .ren_i(ren),
        .rcs_n_i(rcs_n), .osel_i(osel), .dout_o(dout),
        .nempty_o(nempty), .full_o(full), .comp_o(comp)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare scoreboard entries in the cycle they fall due
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item = sbq.pop_front();
            chk(item.req, dout, item.val);
        end
    end

    task automatic drv(input logic [3:0] w, input logic [1:0] ws, input logic [39:0] d,
                       input logic [3:0] r, input logic cs_n);
        @(negedge clk);
        wen = w; wsel = ws; din = d; ren = r; rcs_n = cs_n;
    endtask

    task automatic idle();
        drv(4'b0, 2'd0, 40'd0, 4'b0, 1'b0);
    endtask

    task automatic expect_at(input int dly, input logic [39:0] v, input string req);
        sbq.push_back('{cyc + dly, v, req});
    endtask

    task automatic wr1(input int q, input logic [9:0] v);
        drv(4'b0001, 2'(q), {30'h15555555, v}, 4'b0, 1'b0);
    endtask

    task automatic rd1(input logic [9:0] v, input string req);
        drv(4'b0, 2'd0, 40'd0, 4'b0001, 1'b0);
        expect_at(1, 40'(v), req);
    endtask

    task automatic rdl(input logic [3:0] r, input logic [39:0] v, input string req);
        drv(4'b0, 2'd0, 40'd0, r, 1'b0);
        expect_at(1, v, req);
    endtask

    task automatic do_reset(input logic [1:0] m, input logic f, input logic [1:0] os);
        @(negedge clk);
        rst_n = 1'b0; mode_i = m; fwft_i = f; osel = os;
        wen = '0; ren = '0; rcs_n = 1'b0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R2 dout", dout, 40'd0);
        chk("R2 flags", {27'd0, comp, full, nempty}, 40'd0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // ---------- single-port mode, plain timing ----------
        do_reset(2'd0, 1'b0, 2'd1);
        mode_i = 2'd2;                          // R1: ignored after reset
        wr1(2, 10'h0A1); wr1(2, 10'h0A2); wr1(2, 10'h0A3); wr1(0, 10'h011);
        drv(4'b1110, 2'd3, 40'hFFFFFFFFFF, 4'b0, 1'b0);   // R3: upper enables ignored
        idle();
        chk("R3 R1 nempty", 40'(nempty), 40'(4'b0101));
        chk("R13 full", 40'(full), 40'd0);
        osel = 2'd2;
        idle(); chk("R6 comp before", 40'(comp), 40'd0);
        idle(); chk("R6 comp after", 40'(comp), 40'd1);
        rd1(10'h0A1, "R4 first");
        rd1(10'h0A2, "R4 second");
        drv(4'b0, 2'd0, 40'd0, 4'b0001, 1'b1);           // read while deselected
        idle();
        chk("R5 hold", dout, 40'(10'h0A2));
        chk("R5 no pop", 40'(nempty[2]), 40'd1);
        rd1(10'h0A3, "R4 third");
        rd1(10'h0A3, "R4 empty hold");
        idle();
        chk("R4 drained", 40'(nempty), 40'(4'b0001));
        for (int i = 0; i < 4; i++) wr1(3, 10'(10'h0C0 + i));
        wr1(3, 10'h0FF);                                  // dropped
        wr1(1, 10'h0B0);                                  // other queue still open
        idle();
        chk("R12 full one", 40'(full), 40'(4'b1000));
        chk("R12 nempty", 40'(nempty), 40'(4'b1011));
        osel = 2'd3;
        for (int i = 0; i < 4; i++) rd1(10'(10'h0C0 + i), "R12 drain");
        rd1(10'h0C3, "R12 dropped word absent");
        wr1(1, 10'h0B1); wr1(1, 10'h0B2); wr1(1, 10'h0B3);
        idle();
        chk("R12 q1 full", 40'(full), 40'(4'b0010));
        osel = 2'd1;
        drv(4'b0001, 2'd1, {30'h0, 10'h0BF}, 4'b0001, 1'b0);  // pop and write same edge
        expect_at(1, 40'(10'h0B0), "R12 same-edge read");
        rd1(10'h0B1, "R12 b1"); rd1(10'h0B2, "R12 b2"); rd1(10'h0B3, "R12 b3");
        rd1(10'h0B3, "R12 same-edge write lost");
        idle();
        chk("R12 q1 empty", 40'(nempty[1]), 40'd0);

        // ---------- split mode ----------
        do_reset(2'd1, 1'b0, 2'd0);
        drv(4'b1111, 2'd0, {10'h301, 10'h201, 10'h101, 10'h001}, 4'b0, 1'b0);
        drv(4'b1111, 2'd0, {10'h302, 10'h202, 10'h102, 10'h002}, 4'b0, 1'b0);
        drv(4'b0010, 2'd0, {10'h0, 10'h0, 10'h1AA, 10'h0}, 4'b0, 1'b0);
        drv(4'b0010, 2'd0, {10'h0, 10'h0, 10'h1BB, 10'h0}, 4'b0, 1'b0);
        drv(4'b0011, 2'd0, {10'h0, 10'h0, 10'h1CC, 10'h0CC}, 4'b0, 1'b0);
        idle();
        chk("R12 split full", 40'(full), 40'(4'b0010));
        chk("R9 nempty", 40'(nempty), 40'(4'b1111));
        chk("R7 comp quiet", 40'(comp), 40'd0);
        rdl(4'b1111, {10'h301, 10'h201, 10'h101, 10'h001}, "R9 all lanes");
        rdl(4'b0001, {10'h301, 10'h201, 10'h101, 10'h002}, "R9 lane0");
        rdl(4'b0001, {10'h301, 10'h201, 10'h101, 10'h0CC}, "R12 lane0 accepted");
        rdl(4'b0001, {10'h301, 10'h201, 10'h101, 10'h0CC}, "R9 empty lane holds");
        rdl(4'b1110, {10'h302, 10'h202, 10'h102, 10'h0CC}, "R9 upper lanes");
        rdl(4'b1110, {10'h302, 10'h202, 10'h1AA, 10'h0CC}, "R9 partial");
        rdl(4'b0010, {10'h302, 10'h202, 10'h1BB, 10'h0CC}, "R9 lane1");
        rdl(4'b0010, {10'h302, 10'h202, 10'h1BB, 10'h0CC}, "R12 lane1 write lost");
        idle();
        chk("R13 split drained", 40'(nempty), 40'd0);

        // ---------- copy mode ----------
        do_reset(2'd2, 1'b0, 2'd0);
        for (int i = 1; i <= 4; i++)
            drv(4'b0001, 2'd0, {30'h3FFFFFFF, 10'(10'h050 + i)}, 4'b0, 1'b0);
        idle();
        chk("R10 full", 40'(full), 40'(4'b1111));
        for (int i = 1; i <= 4; i++) begin
            logic [9:0] v;
            v = 10'(10'h050 + i);
            rdl(4'b1011, {v, 10'h0, v, v}, "R10 copies");
        end
        idle();
        chk("R13 one full", 40'(full), 40'(4'b0100));
        chk("R13 one left", 40'(nempty), 40'(4'b0100));
        drv(4'b0001, 2'd0, 40'(10'h0EE), 4'b0, 1'b0);
        idle();
        chk("R11 blocked", 40'(nempty), 40'(4'b0100));
        rdl(4'b0100, {10'h054, 10'h051, 10'h054, 10'h054}, "R10 lane2");
        drv(4'b0001, 2'd0, 40'(10'h0E1), 4'b0, 1'b0);
        idle();
        chk("R10 all written", 40'(nempty), 40'(4'b1111));
        chk("R11 full again", 40'(full), 40'(4'b0100));
        rdl(4'b1011, {10'h0E1, 10'h051, 10'h0E1, 10'h0E1}, "R10 new copy");
        drv(4'b0001, 2'd0, 40'(10'h0E2), 4'b0100, 1'b0);    // pop full queue + copy write
        expect_at(1, {10'h0E1, 10'h052, 10'h0E1, 10'h0E1}, "R11 same-edge read");
        idle();
        chk("R11 same-edge write lost", 40'(nempty), 40'(4'b0100));
        chk("R11 full cleared", 40'(full), 40'd0);

        // ---------- single-port mode, look-ahead timing ----------
        do_reset(2'd0, 1'b1, 2'd1);
        wr1(1, 10'h111); wr1(1, 10'h112); wr1(2, 10'h221);
        idle(); idle();
        chk("R8 shown without read", dout, 40'(10'h111));
        chk("R7 comp", 40'(comp), 40'd1);
        osel = 2'd3;
        idle(); chk("R7 comp k+1", 40'(comp), 40'd1);
        idle(); chk("R7 comp k+2", 40'(comp), 40'd1);
        idle(); chk("R7 comp k+3", 40'(comp), 40'd0);
        chk("R8 empty selection holds", dout, 40'(10'h111));
        osel = 2'd2;
        expect_at(3, 40'(10'h221), "R8 new queue at third edge");
        idle(); chk("R8 k+1", dout, 40'(10'h111));
        idle(); chk("R8 k+2", dout, 40'(10'h111));
        idle();
        osel = 2'd1;
        idle(); idle(); idle();
        chk("R8 back to q1", dout, 40'(10'h111));
        drv(4'b0, 2'd0, 40'd0, 4'b0001, 1'b0);
        idle();
        chk("R8 pop edge", dout, 40'(10'h111));
        drv(4'b0, 2'd0, 40'd0, 4'b0001, 1'b0);
        chk("R8 next word", dout, 40'(10'h112));
        wr1(1, 10'h113);
        chk("R13 q1 emptied", 40'(nempty[1]), 40'd0);
        chk("R8 holds on empty", dout, 40'(10'h112));
        idle(); idle();
        chk("R8 refill shown", dout, 40'(10'h113));

        repeat (4) idle();
        n_chk++;
        if (sbq.size() != 0) begin
            n_err++;
            $display("FAIL R4 scoreboard actual=%0d expected=0", sbq.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule